// File: doc/BRIEF.md
# Selectable-Ceiling Compare Timer

A 16-bit up-counter with three compare channels. A mode input picks the count ceiling: the full 16-bit range, one of three fixed ceilings (8, 9 or 10 bits of ones), the active value of compare channel A, or an externally supplied capture value. When the count sits at the ceiling and the block is enabled, it returns to zero on the next clock and reports this with a one-cycle pulse. A separate one-cycle pulse reports a wrap out of 0xFFFF.

Each channel has a write buffer and an active register. Writes land in the buffer; the active value takes the buffer contents only when the count wraps to zero. This lets software change a compare value, including channel A while it serves as the ceiling, without glitching the running period. A match between the count and an active value sets a sticky flag that is cleared by writing a one, and drives a waveform pin that either toggles per match or acts as a PWM level.

Top module: `cmp_timer16`

## Requirements
- R1: Reset clears count, flags, pulses and waveforms to 0. While `en` is 1 the count rises by one per clock; while `en` is 0 it holds.
- R2: `mode` selects the ceiling: 0 = 0xFFFF, 1 = 0x00FF, 2 = 0x01FF, 3 = 0x03FF, 4 = active value of channel A, 5 = `cap_val` (6 and 7 act as 0). With `en` high and count equal to the ceiling, the next count is 0.
- R3: `top_flag` is 1 for exactly the one cycle after a wrap from the ceiling; `ovf_flag` is 1 for exactly the one cycle after a wrap from 0xFFFF.
- R4: A write strobe on `cmp_wr[i]` (bit 0 = A, 1 = B, 2 = C) loads only channel i's buffer; the active value, which all matching, PWM levels and mode 4 use, takes the buffer only at a wrap to 0.
- R5: When `en` is 1 and count equals channel i's active value, `cmp_flag[i]` is 1 from the next cycle on and stays 1 until cleared.
- R6: A 1 on `flag_clr[i]` for one cycle clears `cmp_flag[i]` at the next edge, unless a match occurs in that same cycle.
- R7: With `pwm_en` = 0, `wave[i]` inverts one cycle after each match of channel i.
- R8: With `pwm_en` = 1, `wave[i]` is 1 while count is below channel i's active value and 0 otherwise.
- R9: In mode 4 with `pwm_en` = 1, `wave[0]` is held at 0; a new channel A value written while running takes effect as the ceiling after the next wrap.
- R10: In mode 5 channel A keeps normal PWM output while `cap_val` sets the ceiling.
- R11: If the count is above a newly selected ceiling, it keeps rising to 0xFFFF and then wraps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Count enable |
| mode | input | 3 | Ceiling select |
| pwm_en | input | 1 | 1 = PWM waveforms, 0 = toggle on match |
| cmp_wr | input | 3 | Per-channel buffer write strobes |
| cmp_wdata | input | 16 | Compare write data |
| cap_val | input | 16 | Capture register contents used as ceiling in mode 5 |
| flag_clr | input | 3 | Write-one-to-clear for compare flags |
| count | output | 16 | Current count |
| cmp_flag | output | 3 | Sticky compare match flags |
| top_flag | output | 1 | One-cycle pulse after a wrap from the ceiling |
| ovf_flag | output | 1 | One-cycle pulse after a wrap from 0xFFFF |
| wave | output | 3 | Waveform outputs |

## Verification
The count, `top_flag`, `ovf_flag`, the flags and the toggle waveforms are all registered, so each is due at the first clock edge after the enabled cycle that causes it; PWM levels follow the count and active value combinationally, so they are due at the same edge that moves the count. A buffered write shows up only after the following wrap, one edge after the count leaves the ceiling. Stimulus is driven on the falling edge and every check samples on a falling edge after a counted number of rising edges, with the expected count derived from that number modulo the selected ceiling.

// File: rtl/ct_pkg.sv
package ct_pkg;
  // Ceiling source selected by the mode input
  typedef enum logic [2:0] {
    CEIL_FULL = 3'd0,
    CEIL_B8   = 3'd1,
    CEIL_B9   = 3'd2,
    CEIL_B10  = 3'd3,
    CEIL_CHA  = 3'd4,
    CEIL_CAP  = 3'd5
  } ceil_src_e;

  localparam int unsigned NUM_CH = 3;
  localparam int unsigned CH_A   = 0;
endpackage

// File: rtl/ct_ceiling_sel.sv
module ct_ceiling_sel
  import ct_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic [2:0]    mode,
  input  logic [CW-1:0] cha_active,
  input  logic [CW-1:0] cap_val,
  output logic [CW-1:0] ceil_val,
  output logic          cha_is_ceil
);
  // Value with the lowest n bits set, clipped to the counter width
  function automatic logic [CW-1:0] low_ones(input int unsigned n);
    logic [CW-1:0] v;
    v = '0;
    for (int unsigned i = 0; i < CW; i++) begin
      if (i < n) v[i] = 1'b1;
    end
    return v;
  endfunction

  localparam logic [CW-1:0] CEIL8  = low_ones(8);
  localparam logic [CW-1:0] CEIL9  = low_ones(9);
  localparam logic [CW-1:0] CEIL10 = low_ones(10);
  localparam logic [CW-1:0] CEILF  = low_ones(CW);

  ceil_src_e src;
  assign src = ceil_src_e'(mode);

  always_comb begin
    case (src)
      CEIL_FULL: ceil_val = CEILF;
      CEIL_B8:   ceil_val = CEIL8;
      CEIL_B9:   ceil_val = CEIL9;
      CEIL_B10:  ceil_val = CEIL10;
      CEIL_CHA:  ceil_val = cha_active;
      CEIL_CAP:  ceil_val = cap_val;
      default:   ceil_val = CEILF;
    endcase
  end

  assign cha_is_ceil = (src == CEIL_CHA);
endmodule

// File: rtl/ct_counter.sv
module ct_counter #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] ceil_val,
  output logic [CW-1:0] count,
  output logic          wrap,
  output logic          top_pulse,
  output logic          ovf_pulse
);
  logic [CW-1:0] cnt_q;
  logic          top_q, ovf_q;
  logic          at_ceil, at_max;

  function automatic logic [CW-1:0] next_count(input logic [CW-1:0] c,
                                               input logic          w);
    return w ? '0 : c + 1'b1;
  endfunction

  assign at_ceil = (cnt_q == ceil_val);
  assign at_max  = &cnt_q;
  assign wrap    = en & (at_ceil | at_max);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      top_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      if (en) cnt_q <= next_count(cnt_q, wrap);
      top_q <= en & at_ceil;
      ovf_q <= en & at_max;
    end
  end

  assign count     = cnt_q;
  assign top_pulse = top_q;
  assign ovf_pulse = ovf_q;

  // R1: count frozen while disabled
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt_q));
  // R2: ceiling reached with enable returns to bottom
  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt_q == ceil_val) |=> (cnt_q == '0));
  // R3: pulses only coincide with bottom
  p_top_bottom_r3: assert property (@(posedge clk) disable iff (!rst_n)
    top_q |-> (cnt_q == '0));
  p_ovf_bottom_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> (cnt_q == '0));
  // R3: pulse lasts one cycle unless the ceiling is zero
  p_top_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (top_q && ceil_val != '0) |=> !top_q);
endmodule

// File: rtl/ct_cmp_chan.sv
module ct_cmp_chan #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          wr,
  input  logic [CW-1:0] wdata,
  input  logic          wrap,
  input  logic [CW-1:0] count,
  input  logic          pwm,
  input  logic          suppress,
  input  logic          clr,
  output logic [CW-1:0] active,
  output logic          flag,
  output logic          wave
);
  logic [CW-1:0] buf_q, act_q;
  logic          flag_q, tog_q;
  logic          match;

  function automatic logic pwm_level(input logic [CW-1:0] c,
                                     input logic [CW-1:0] cmp);
    return c < cmp;
  endfunction

  assign match = en & (count == act_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      act_q  <= '0;
      flag_q <= 1'b0;
      tog_q  <= 1'b0;
    end else begin
      if (wr)    buf_q <= wdata;
      if (wrap)  act_q <= buf_q;
      flag_q <= match | (flag_q & ~clr);
      if (match) tog_q <= ~tog_q;
    end
  end

  assign active = act_q;
  assign flag   = flag_q;
  assign wave   = pwm ? (~suppress & pwm_level(count, act_q)) : tog_q;

  // R4: active value moves only at a wrap
  p_active_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(act_q));
  // R5: flag is sticky without a clear
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);
  // R6: clear without a match empties the flag
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !match) |=> !flag_q);
  // R7: toggle waveform changes only after a match
  p_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !match |=> $stable(tog_q));
endmodule

// File: rtl/cmp_timer16.sv
module cmp_timer16
  import ct_pkg::*;
#(
  parameter int unsigned CW  = 16,
  parameter int unsigned NCH = NUM_CH
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic [2:0]     mode,
  input  logic           pwm_en,
  input  logic [NCH-1:0] cmp_wr,
  input  logic [CW-1:0]  cmp_wdata,
  input  logic [CW-1:0]  cap_val,
  input  logic [NCH-1:0] flag_clr,
  output logic [CW-1:0]  count,
  output logic [NCH-1:0] cmp_flag,
  output logic           top_flag,
  output logic           ovf_flag,
  output logic [NCH-1:0] wave
);
  logic [CW-1:0] ceil_val;
  logic          cha_is_ceil;
  logic          wrap;
  logic [CW-1:0] active [NCH];

  ct_ceiling_sel #(.CW(CW)) u_sel (
    .mode        (mode),
    .cha_active  (active[CH_A]),
    .cap_val     (cap_val),
    .ceil_val    (ceil_val),
    .cha_is_ceil (cha_is_ceil)
  );

  ct_counter #(.CW(CW)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .ceil_val  (ceil_val),
    .count     (count),
    .wrap      (wrap),
    .top_pulse (top_flag),
    .ovf_pulse (ovf_flag)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic sup;
    if (i == CH_A) begin : g_a
      assign sup = cha_is_ceil & pwm_en;
    end else begin : g_other
      assign sup = 1'b0;
    end

    ct_cmp_chan #(.CW(CW)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .wr       (cmp_wr[i]),
      .wdata    (cmp_wdata),
      .wrap     (wrap),
      .count    (count),
      .pwm      (pwm_en),
      .suppress (sup),
      .clr      (flag_clr[i]),
      .active   (active[i]),
      .flag     (cmp_flag[i]),
      .wave     (wave[i])
    );
  end

  // R9: channel A silent in PWM while it is the ceiling
  p_cha_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_en && cha_is_ceil) |-> !wave[CH_A]);
endmodule

// File: tb/tb_cmp_timer16.sv
module tb_cmp_timer16;
  localparam int CLK_P = 10;
  localparam int WD_CYCLES = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [2:0]  mode = '0;
  logic        pwm_en = 1'b0;
  logic [2:0]  cmp_wr = '0;
  logic [15:0] cmp_wdata = '0;
  logic [15:0] cap_val = '0;
  logic [2:0]  flag_clr = '0;
  logic [15:0] count;
  logic [2:0]  cmp_flag;
  logic        top_flag, ovf_flag;
  logic [2:0]  wave;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  cmp_timer16 dut (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .pwm_en(pwm_en),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .cap_val(cap_val),
    .flag_clr(flag_clr), .count(count), .cmp_flag(cmp_flag),
    .top_flag(top_flag), .ovf_flag(ovf_flag), .wave(wave)
  );

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; en = 1'b0; mode = '0; pwm_en = 1'b0;
    cmp_wr = '0; cmp_wdata = '0; cap_val = '0; flag_clr = '0;
    run(2);
    rst_n = 1'b1;
  endtask

  task automatic wr_buf(input logic [2:0] m, input logic [15:0] d);
    cmp_wr = m; cmp_wdata = d;
    run(1);
    cmp_wr = '0;
  endtask

  task automatic t_reset_count();
    do_reset();
    chk("R1 reset count", count, 0);
    chk("R1 reset flags", {cmp_flag, top_flag, ovf_flag, wave}, 0);
    run(3);
    chk("R1 hold while disabled", count, 0);
    en = 1'b1; run(5);
    chk("R1 count up", count, 5);
    en = 1'b0; run(3);
    chk("R1 hold after stop", count, 5);
  endtask

  task automatic t_fixed_ceilings();
    do_reset(); mode = 3'd1; en = 1'b1;
    run(255);
    chk("R2 mode1 at ceiling", count, 16'h00FF);
    chk("R3 no top pulse yet", top_flag, 0);
    run(1);
    chk("R2 mode1 wrap", count, 0);
    chk("R3 top pulse", top_flag, 1);
    chk("R3 no ovf at 0xFF", ovf_flag, 0);
    run(1);
    chk("R3 top pulse one cycle", {count, 15'd0, top_flag}, {16'd1, 16'd0});
    do_reset(); mode = 3'd2; en = 1'b1;
    run(16'h1FF);
    chk("R2 mode2 at ceiling", count, 16'h01FF);
    run(1);
    chk("R2 mode2 wrap", {count, 15'd0, top_flag}, {16'd0, 16'd1});
    do_reset(); mode = 3'd3; en = 1'b1;
    run(16'h3FF);
    chk("R2 mode3 at ceiling", count, 16'h03FF);
    run(1);
    chk("R2 mode3 wrap", {count, 15'd0, top_flag}, {16'd0, 16'd1});
    do_reset(); mode = 3'd0; en = 1'b1;
    run(16'h400);
    chk("R2 mode0 passes 10-bit ceiling", count, 16'h0400);
  endtask

  task automatic t_above_ceiling();
    do_reset(); mode = 3'd3; en = 1'b1;
    run(16'h300);
    chk("R11 setup", count, 16'h0300);
    mode = 3'd1;
    run(16'hFFFF - 16'h300);
    chk("R11 runs to max", count, 16'hFFFF);
    run(1);
    chk("R11 wraps from max", count, 0);
    chk("R3 ovf pulse", ovf_flag, 1);
    chk("R3 no top pulse on overflow", top_flag, 0);
    run(1);
    chk("R3 ovf pulse one cycle", ovf_flag, 0);
  endtask

  task automatic t_buffer_flags();
    do_reset(); mode = 3'd1;
    wr_buf(3'b010, 16'd10);
    en = 1'b1; run(1);
    chk("R5 flags from initial match", cmp_flag, 3'b111);
    flag_clr = 3'b111; run(1); flag_clr = '0;
    chk("R6 clear", {13'd0, cmp_flag, count}, {16'd0, 16'd2});
    run(18);
    chk("R4 buffer not active before wrap", {cmp_flag[1], count}, {1'b0, 16'd20});
    run(246);
    chk("R4 count at new value", count, 16'd10);
    chk("R5 flag not yet set", cmp_flag[1], 0);
    run(1);
    chk("R5 flag set after match", cmp_flag[1], 1);
    run(5);
    chk("R5 flag sticky", cmp_flag[1], 1);
    flag_clr = 3'b010; run(1); flag_clr = '0;
    chk("R6 clear one channel", cmp_flag[1], 0);
  endtask

  task automatic t_toggle();
    do_reset(); mode = 3'd1; pwm_en = 1'b0;
    wr_buf(3'b010, 16'd5);
    en = 1'b1; run(1);
    chk("R7 toggle on first match", wave, 3'b111);
    run(255);
    chk("R7 no toggle without match", {13'd0, wave, count}, {16'd7, 16'd0});
    run(1);
    chk("R7 A and C toggle back", wave, 3'b010);
    run(4);
    chk("R7 B holds before its match", wave, 3'b010);
    run(1);
    chk("R7 B toggles after match", wave, 3'b000);
  endtask

  task automatic t_pwm();
    do_reset(); mode = 3'd1; pwm_en = 1'b1;
    chk("R8 pwm before load", wave, 3'b000);
    wr_buf(3'b001, 16'h40);
    wr_buf(3'b010, 16'h80);
    en = 1'b1; run(256);
    chk("R8 pwm at bottom", {13'd0, wave, count}, {16'd3, 16'd0});
    run(16'h40);
    chk("R8 pwm A ends", wave, 3'b010);
    run(16'h40);
    chk("R8 pwm B ends", wave, 3'b000);
  endtask

  task automatic t_cha_ceiling();
    do_reset(); mode = 3'd4; pwm_en = 1'b1;
    wr_buf(3'b001, 16'h20);
    wr_buf(3'b010, 16'h10);
    en = 1'b1; run(1);
    chk("R9 zero ceiling wraps", {count, 15'd0, top_flag}, {16'd0, 16'd1});
    run(5);
    chk("R9 A silent, B pwm", {13'd0, wave, count}, {16'd2, 16'd5});
    run(16'h1B);
    chk("R9 reaches A ceiling", count, 16'h20);
    run(1);
    chk("R9 wrap at A ceiling", {count, 15'd0, top_flag}, {16'd0, 16'd1});
    wr_buf(3'b001, 16'h08);
    run(16'h1F);
    chk("R9 old ceiling kept", count, 16'h20);
    run(1);
    chk("R9 wrap before new ceiling", count, 0);
    run(8);
    chk("R9 new ceiling reached", count, 16'h08);
    run(1);
    chk("R9 wrap at new ceiling", {count, 15'd0, top_flag}, {16'd0, 16'd1});
  endtask

  task automatic t_cap_ceiling();
    do_reset(); mode = 3'd5; pwm_en = 1'b1; cap_val = 16'h30;
    wr_buf(3'b001, 16'h10);
    en = 1'b1; run(16'h30);
    chk("R10 reaches capture ceiling", count, 16'h30);
    run(1);
    chk("R10 wrap at capture ceiling", {count, 15'd0, top_flag}, {16'd0, 16'd1});
    run(4);
    chk("R10 A pwm high", wave[0], 1);
    run(12);
    chk("R10 A pwm low", {15'd0, wave[0], count}, {16'd0, 16'h10});
  endtask

  initial begin
    run(WD_CYCLES);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset_count();
    t_fixed_ceilings();
    t_above_ceiling();
    t_buffer_flags();
    t_toggle();
    t_pwm();
    t_cha_ceiling();
    t_cap_ceiling();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule